// File: doc/BRIEF.md
# Register Shift Unit

This block carries out register shifts for a processor datapath: left or right, arithmetic (sign-preserving) or logical, on one 32-bit register or on a register pair treated as a single 64-bit value. The even register of a pair holds the upper half and the sign. The odd register holds the lower half. The shift amount is not an address. It is formed from an optional base register value plus a 12-bit displacement, and only the low 6 bits of that sum are used.

The surrounding pipeline presents the operation code, the destination register number, the current register contents and the count operands, and pulses `start` for one cycle. One clock later the unit presents the new register values, the overflow flag, the specification-error flag and the condition code, and pulses `done`. The outputs hold until the next `start`. Arithmetic shifts update the 2-bit condition code. Logical shifts leave it as it was.

Top module: `shu_shift_unit`

## Requirements
- R1: The shift count is bits [5:0] of (base_none ? 0 : base_val) + zero-extended disp. Higher sum bits are ignored.
- R2: op[1]=0 (logical) with op[0]=0 (left) moves all bits toward the MSB and fills the freed low bits with 0. The MSB may change.
- R3: op[1]=1 (arithmetic) with op[0]=0 keeps the MSB fixed and shifts only the magnitude bits, filling the low bits with 0. ovf is 1 exactly when any bit shifted out of the magnitude (including shifted-in zeros, for counts beyond the magnitude width) differs from the kept sign.
- R4: op[0]=1 (right) discards the low bits. An arithmetic right shift fills the top bits with copies of the sign, so -1 stays -1. A logical right shift fills the top bits with 0.
- R5: op[2]=1 (double) shifts {hi_in, lo_in} as one 64-bit value with the sign at hi_in[31]. Example: an arithmetic right shift by 32 of hi=0xFFFFFF9C gives hi=0xFFFFFFFF and lo=0xFFFFFF9C.
- R6: A double shift with odd r1_num (r1_num[0]=1) sets spec_err. It returns hi_in and lo_in unchanged, clears ovf and leaves cc unchanged. Any other operation clears spec_err.
- R7: After an arithmetic shift, cc is 3 on overflow; otherwise it is 0 if the result is zero, 1 if the result is negative and 2 if it is positive. The result is 64-bit for double shifts and 32-bit for single shifts. Logical shifts keep cc unchanged.
- R8: A single shift (op[2]=0) acts on hi_in only and returns lo_out = lo_in.
- R9: Results and done appear on the first clock edge after start is sampled high. done is high for exactly that one cycle. Without start, all result outputs hold their values.
- R10: Synchronous reset clears hi_out, lo_out, cc, ovf, spec_err and done to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to perform a shift |
| op | input | 3 | Operation code: [2] double, [1] arithmetic, [0] right |
| r1_num | input | 4 | Destination register number; must be even for double shifts |
| hi_in | input | 32 | Single operand, or even (upper) register of a pair |
| lo_in | input | 32 | Odd (lower) register of a pair |
| base_val | input | 32 | Base register contents for the count sum |
| base_none | input | 1 | Base field is zero: use 0 instead of base_val |
| disp | input | 12 | Displacement added to the base |
| hi_out | output | 32 | New single register or upper register value |
| lo_out | output | 32 | New lower register value |
| cc | output | 2 | Condition code |
| ovf | output | 1 | Arithmetic left shift lost a significant bit |
| spec_err | output | 1 | Double shift requested with an odd register number |
| done | output | 1 | Result valid pulse |

## Verification
The assertions assume that `start` is a single-cycle pulse and that `op` and the data inputs are valid whenever `start` is high. They make no assumption about inputs between requests. The stimulus therefore always releases `start` after one edge and separates requests with idle cycles, and it changes inputs only on the falling clock edge. Random requests draw from all eight operation codes, odd and even register numbers, and register values that often take the extremes (zero, all ones, the sign bit alone). Directed cases cover the count sum wrapping past 6 bits, and counts equal to or beyond the operand width.

// File: rtl/shu_pkg.sv
package shu_pkg;
  // Operation code bit positions
  localparam int OPB_RIGHT = 0;
  localparam int OPB_ALG   = 1;
  localparam int OPB_DBL   = 2;

  typedef enum logic [1:0] {
    CC_ZERO = 2'd0,
    CC_NEG  = 2'd1,
    CC_POS  = 2'd2,
    CC_OVF  = 2'd3
  } cc_e;
endpackage

// File: rtl/shu_count.sv
module shu_count #(
  parameter int W     = 32,
  parameter int DISPW = 12,
  parameter int CW    = 6
) (
  input  logic [W-1:0]     base_val,
  input  logic             base_none,
  input  logic [DISPW-1:0] disp,
  output logic [CW-1:0]    cnt
);
  logic [W-1:0] base_eff;
  logic [W-1:0] sum;

  assign base_eff = base_none ? '0 : base_val;
  assign sum      = base_eff + W'(disp);
  assign cnt      = sum[CW-1:0];
endmodule

// File: rtl/shu_barrel.sv
module shu_barrel #(
  parameter int DW = 64,
  parameter int CW = 6
) (
  input  logic [DW-1:0] v,
  input  logic [CW-1:0] n,
  input  logic          right,
  input  logic          alg,
  output logic [DW-1:0] res,
  output logic          ovf
);
  logic [DW-1:0] stg [0:CW];
  logic          fill;
  logic [DW-2:0] lost_mask;
  logic [DW-2:0] diff;

  assign fill   = right & alg & v[DW-1];
  assign stg[0] = v;

  // log2 stages; stage k moves by 2**k positions
  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = !n[k] ? stg[k] :
                      right ? {{SH{fill}}, stg[k][DW-1:SH]} :
                              {stg[k][DW-1-SH:0], {SH{1'b0}}};
  end

  // arithmetic left keeps the sign in place
  assign res = (alg && !right) ? {v[DW-1], stg[CW][DW-2:0]} : stg[CW];

  // top n magnitude bits leave the word; any that differ from sign is overflow
  assign lost_mask = ~({(DW-1){1'b1}} >> n);
  assign diff      = v[DW-2:0] ^ {(DW-1){v[DW-1]}};
  assign ovf       = alg & ~right & (|(diff & lost_mask));
endmodule

// File: rtl/shu_ccgen.sv
module shu_ccgen
  import shu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] res,
  input  logic           dbl,
  input  logic           ovf,
  output cc_e            cc_new
);
  logic is_zero;

  assign is_zero = dbl ? (res == '0) : (res[2*W-1:W] == '0);

  always_comb begin
    if (ovf)               cc_new = CC_OVF;
    else if (is_zero)      cc_new = CC_ZERO;
    else if (res[2*W-1])   cc_new = CC_NEG;
    else                   cc_new = CC_POS;
  end
endmodule

// File: rtl/shu_shift_unit.sv
module shu_shift_unit
  import shu_pkg::*;
#(
  parameter int W     = 32,
  parameter int DISPW = 12,
  parameter int RNW   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [RNW-1:0]   r1_num,
  input  logic [W-1:0]     hi_in,
  input  logic [W-1:0]     lo_in,
  input  logic [W-1:0]     base_val,
  input  logic             base_none,
  input  logic [DISPW-1:0] disp,
  output logic [W-1:0]     hi_out,
  output logic [W-1:0]     lo_out,
  output logic [1:0]       cc,
  output logic             ovf,
  output logic             spec_err,
  output logic             done
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW);

  logic          dbl, right, alg, bad_pair;
  logic [CW-1:0] cnt;
  logic [DW-1:0] operand, shifted;
  logic          sh_ovf;
  cc_e           cc_new;

  assign dbl      = op[OPB_DBL];
  assign right    = op[OPB_RIGHT];
  assign alg      = op[OPB_ALG];
  assign bad_pair = dbl & r1_num[0];
  // single operand sits in the upper half; lower half supplies zero fill
  assign operand  = dbl ? {hi_in, lo_in} : {hi_in, {W{1'b0}}};

  shu_count #(.W(W), .DISPW(DISPW), .CW(CW)) u_count (
    .base_val (base_val),
    .base_none(base_none),
    .disp     (disp),
    .cnt      (cnt)
  );

  shu_barrel #(.DW(DW), .CW(CW)) u_barrel (
    .v    (operand),
    .n    (cnt),
    .right(right),
    .alg  (alg),
    .res  (shifted),
    .ovf  (sh_ovf)
  );

  shu_ccgen #(.W(W)) u_cc (
    .res   (shifted),
    .dbl   (dbl),
    .ovf   (sh_ovf),
    .cc_new(cc_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_out   <= '0;
      lo_out   <= '0;
      cc       <= CC_ZERO;
      ovf      <= 1'b0;
      spec_err <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        if (bad_pair) begin
          hi_out   <= hi_in;
          lo_out   <= lo_in;
          ovf      <= 1'b0;
          spec_err <= 1'b1;
        end else begin
          hi_out   <= shifted[DW-1:W];
          lo_out   <= dbl ? shifted[W-1:0] : lo_in;
          ovf      <= sh_ovf;
          spec_err <= 1'b0;
          if (alg) cc <= cc_new;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(hi_out) && $stable(lo_out) && $stable(cc) && !done));

  assert_odd_pair_R6: assert property (@(posedge clk) disable iff (rst)
    (start && op[OPB_DBL] && r1_num[0]) |=>
      (spec_err && !ovf && hi_out == $past(hi_in) && lo_out == $past(lo_in)
       && cc == $past(cc)));

  assert_single_low_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !op[OPB_DBL]) |=> (lo_out == $past(lo_in)));

  assert_logical_cc_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !op[OPB_ALG]) |=> (cc == $past(cc) && !ovf));

  assert_sign_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (start && op == 3'b010) |=> (hi_out[W-1] == $past(hi_in[W-1])));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (cc == CC_OVF));
endmodule

// File: tb/tb_shu_shift_unit.sv
module tb_shu_shift_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  op;
  logic [3:0]  r1_num;
  logic [31:0] hi_in, lo_in, base_val;
  logic        base_none;
  logic [11:0] disp;
  logic [31:0] hi_out, lo_out;
  logic [1:0]  cc;
  logic        ovf, spec_err, done;

  int errors = 0;
  int checks = 0;
  logic [1:0] cc_model;

  always #5 clk = ~clk;

  shu_shift_unit dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .r1_num(r1_num),
    .hi_in(hi_in), .lo_in(lo_in), .base_val(base_val), .base_none(base_none),
    .disp(disp), .hi_out(hi_out), .lo_out(lo_out), .cc(cc), .ovf(ovf),
    .spec_err(spec_err), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model computed from the requirements
  function automatic void model(input logic [2:0] o, input logic [31:0] h,
                                input logic [31:0] l, input logic [5:0] n,
                                output logic [31:0] eh, output logic [31:0] el,
                                output logic eo);
    logic [63:0] v, r;
    logic [31:0] s32;
    logic s, b;
    eo = 1'b0;
    if (o[2]) begin
      v = {h, l};
      s = v[63];
      if (o[0]) r = o[1] ? 64'($signed(v) >>> n) : (v >> n);
      else begin
        r = v << n;
        if (o[1]) begin
          r[63] = s;
          for (int i = 1; i <= 63; i++)
            if (i <= int'(n) && v[63-i] != s) eo = 1'b1;
        end
      end
      eh = r[63:32];
      el = r[31:0];
    end else begin
      s = h[31];
      if (o[0]) s32 = o[1] ? 32'($signed(h) >>> n) : (h >> n);
      else begin
        s32 = h << n;
        if (o[1]) begin
          s32[31] = s;
          for (int i = 1; i <= 63; i++) begin
            b = (i <= 31) ? h[31-i] : 1'b0;
            if (i <= int'(n) && b != s) eo = 1'b1;
          end
        end
      end
      eh = s32;
      el = l;
    end
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [3:0] rn,
                        input logic [31:0] h, input logic [31:0] l,
                        input logic [31:0] bv, input logic bn,
                        input logic [11:0] d);
    logic [31:0] bsum, eh, el;
    logic [5:0]  n;
    logic        eo, bad;
    string       rq;
    @(negedge clk);
    op = o; r1_num = rn; hi_in = h; lo_in = l;
    base_val = bv; base_none = bn; disp = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: count from the low six bits of base plus displacement
    bsum = (bn ? 32'd0 : bv) + {20'd0, d};
    n    = bsum[5:0];
    bad  = o[2] & rn[0];
    rq   = o[2] ? "R5" : (o[0] ? "R4" : (o[1] ? "R3" : "R2"));
    if (bad) begin
      eh = h; el = l; eo = 1'b0;
      chk("R6", "hi", {32'd0, hi_out}, {32'd0, eh});
      chk("R6", "lo", {32'd0, lo_out}, {32'd0, el});
    end else begin
      model(o, h, l, n, eh, el, eo);
      chk(rq, "hi", {32'd0, hi_out}, {32'd0, eh});
      chk(o[2] ? "R5" : "R8", "lo", {32'd0, lo_out}, {32'd0, el});
      if (o[1] && !bad) begin
        if (eo) cc_model = 2'd3;
        else if ((o[2] && {eh, el} == 64'd0) || (!o[2] && eh == 32'd0)) cc_model = 2'd0;
        else if (eh[31]) cc_model = 2'd1;
        else cc_model = 2'd2;
      end
    end
    chk("R3", "ovf", {63'd0, ovf}, {63'd0, eo});
    chk("R6", "spec_err", {63'd0, spec_err}, {63'd0, bad});
    chk("R7", "cc", {62'd0, cc}, {62'd0, cc_model});
    chk("R9", "done", {63'd0, done}, 64'd1);
  endtask

  task automatic idle_check;
    logic [31:0] h0, l0;
    logic [1:0]  c0;
    h0 = hi_out; l0 = lo_out; c0 = cc;
    hi_in = ~hi_in; lo_in = ~lo_in; disp = disp + 12'd1;
    @(negedge clk);
    chk("R9", "idle hi", {32'd0, hi_out}, {32'd0, h0});
    chk("R9", "idle lo", {32'd0, lo_out}, {32'd0, l0});
    chk("R9", "idle cc", {62'd0, cc}, {62'd0, c0});
    chk("R9", "idle done", {63'd0, done}, 64'd0);
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom % 6)
      0: return 32'd0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'd1 << ($urandom % 32);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    rst = 1'b1; start = 1'b0; op = '0; r1_num = '0; hi_in = '0; lo_in = '0;
    base_val = '0; base_none = 1'b1; disp = '0;
    cc_model = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10", "hi", {32'd0, hi_out}, 64'd0);
    chk("R10", "lo", {32'd0, lo_out}, 64'd0);
    chk("R10", "cc", {62'd0, cc}, 64'd0);
    chk("R10", "flags", {61'd0, ovf, spec_err, done}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R3: 2**28 shifted arithmetically left by 3 loses a bit -> overflow
    run_op(3'b010, 4'd4, 32'h1000_0000, 32'h1234_5678, 32'd0, 1'b1, 12'd3);
    chk("R3", "directed hi", {32'd0, hi_out}, 64'd0);
    chk("R7", "directed cc ovf", {62'd0, cc}, 64'd3);
    // R7: logical left keeps cc
    run_op(3'b000, 4'd4, 32'h0000_00F0, 32'd0, 32'd0, 1'b1, 12'd4);
    chk("R7", "logical keeps cc", {62'd0, cc}, 64'd3);
    chk("R2", "directed hi", {32'd0, hi_out}, 64'h0000_0F00);
    // R4: -1 arithmetic right stays -1, cc negative
    run_op(3'b011, 4'd6, 32'hFFFF_FFFF, 32'd7, 32'd0, 1'b1, 12'd5);
    chk("R4", "minus one", {32'd0, hi_out}, 64'hFFFF_FFFF);
    chk("R7", "negative cc", {62'd0, cc}, 64'd1);
    // R5: double arithmetic right by 32 of -100
    run_op(3'b111, 4'd8, 32'hFFFF_FF9C, 32'hAAAA_5555, 32'd0, 1'b1, 12'd32);
    chk("R5", "pair hi", {32'd0, hi_out}, 64'hFFFF_FFFF);
    chk("R5", "pair lo", {32'd0, lo_out}, 64'hFFFF_FF9C);
    // R1: base ignored when base_none; sum wraps to count 1
    run_op(3'b001, 4'd2, 32'h8000_0000, 32'd0, 32'h0000_003F, 1'b0, 12'd2);
    chk("R1", "wrap count", {32'd0, hi_out}, 64'h4000_0000);
    run_op(3'b001, 4'd2, 32'h8000_0000, 32'd0, 32'h0000_0010, 1'b1, 12'd1);
    chk("R1", "base ignored", {32'd0, hi_out}, 64'h4000_0000);
    // R6: odd register on a double shift
    run_op(3'b110, 4'd9, 32'h0F0F_0F0F, 32'h1111_2222, 32'd0, 1'b1, 12'd8);
    chk("R6", "odd pair", {63'd0, spec_err}, 64'd1);
    idle_check();
    // R3: negative single with count beyond width overflows
    run_op(3'b010, 4'd0, 32'h8000_0000, 32'd0, 32'd0, 1'b1, 12'd40);
    chk("R3", "big count ovf", {63'd0, ovf}, 64'd1);
    // R7: zero result gives cc 0
    run_op(3'b011, 4'd0, 32'h0000_0003, 32'd0, 32'd0, 1'b1, 12'd2);
    chk("R7", "zero cc", {62'd0, cc}, 64'd0);

    for (int t = 0; t < 400; t++) begin
      run_op(3'($urandom % 8), 4'($urandom % 16), pick_val(), pick_val(),
             $urandom, ($urandom % 4) == 0, 12'($urandom));
      if ((t % 10) == 0) idle_check();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule